// File: doc/BRIEF.md
# GPIO Interrupt Line Router

This block sits between three banks of general purpose I/O interrupt sources and a platform interrupt controller that has a fixed number of GPIO inputs. Bank 0 has 14 interrupt lines, bank 1 has 24 and bank 2 has 32. Together that is more lines than the controller accepts, so 32 of the controller inputs are shared. A 32-bit route-select register decides, one line at a time, whether a shared input is driven by its bank 0 or bank 1 source, or by the bank 2 source with the same index.

Every source that loses its direct line is not dropped. Each bank has an overflow output that is the OR of that bank's displaced sources, and a separate 3-bit enable register gates each overflow output on its own. Six bank 1 sources (bits 18 to 23) always keep dedicated lines. All 41 outputs come from one rank of flops, so rewriting the select register never produces a combinational glitch toward the controller.

Software writes the select value through one strobe and the overflow enables through a second. A write is sampled on a rising clock edge. The new routing reaches the outputs on the edge after that.

Top module: `gpio_irq_router`

## Requirements
- R1: While reset is high, and on the first edge that samples it, all 41 outputs are 0 and both control registers clear: select is 0 and all overflow enables are off.
- R2: With select bit k clear, for k from 0 to 13, output k equals bank 0 bit k.
- R3: With select bit k clear, for k from 14 to 31, output k equals bank 1 bit k-14.
- R4: With select bit k set, for k from 0 to 31, output k equals bank 2 bit k.
- R5: Outputs 32 to 37 equal bank 1 bits 18 to 23 in that order, whatever the select value.
- R6: Output 38 equals enable bit 0 AND the OR of every bank 0 bit k whose select bit k is set.
- R7: Output 39 equals enable bit 1 AND the OR of every bank 1 bit j (j from 0 to 17) whose select bit j+14 is set. Bank 1 bits 18 to 23 never affect output 39.
- R8: Output 40 equals enable bit 2 AND the OR of every bank 2 bit k whose select bit k is clear. After reset, bank 2 therefore reaches only this line.
- R9: A change on a bank input shows at the outputs after one rising edge. A select or enable write sampled at edge t changes the outputs at edge t+1.
- R10: A select write leaves the enables unchanged, and an enable write leaves the select unchanged. When both strobes are high in the same cycle, both registers load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel_we | input | 1 | Write strobe for the route-select register |
| sel_wdata | input | 32 | New select value; bit k set gives shared line k to bank 2 |
| nd_en_we | input | 1 | Write strobe for the overflow enable register |
| nd_en_wdata | input | 3 | New enables; bit b gates the overflow line of bank b |
| bank0_irq | input | 14 | Bank 0 interrupt sources |
| bank1_irq | input | 24 | Bank 1 interrupt sources |
| bank2_irq | input | 32 | Bank 2 interrupt sources |
| irq_out | output | 41 | Lines to the interrupt controller: 0-31 shared, 32-37 fixed, 38-40 overflow per bank |

## Verification
The assertions assume that the bank inputs and the write strobes change only between clock edges and hold steady around each rising edge. Under that assumption, registered outputs can be compared with the inputs sampled one edge earlier. The bench drives every input on the falling edge and reads the outputs on a later falling edge. A flag that rises on the first edge after reset keeps the one-cycle history checks from reading values captured while reset was active.

// File: rtl/gpio_irq_router_pkg.sv
package gpio_irq_router_pkg;

    // Default bank sizes; the shared line count equals the bank 2 width.
    localparam int unsigned DEF_B0_W     = 14;
    localparam int unsigned DEF_B1_W     = 24;
    localparam int unsigned DEF_SHARED_W = 32;
    localparam int unsigned NUM_BANKS    = 3;

    // Index of each bank's overflow line within the overflow group.
    typedef enum logic [1:0] {
        BANK_0 = 2'd0,
        BANK_1 = 2'd1,
        BANK_2 = 2'd2
    } bank_idx_e;

endpackage

// File: rtl/gpio_irq_route_ctrl.sv
module gpio_irq_route_ctrl #(
    parameter int unsigned SHARED_W = gpio_irq_router_pkg::DEF_SHARED_W,
    parameter int unsigned NB       = gpio_irq_router_pkg::NUM_BANKS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sel_we,
    input  logic [SHARED_W-1:0] sel_wdata,
    input  logic                en_we,
    input  logic [NB-1:0]       en_wdata,
    output logic [SHARED_W-1:0] sel_q_o,
    output logic [NB-1:0]       en_q_o
);

    typedef struct packed {
        logic [SHARED_W-1:0] sel;
        logic [NB-1:0]       en;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (sel_we) ctrl_d.sel = sel_wdata;
        if (en_we)  ctrl_d.en  = en_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

    assign sel_q_o = ctrl_q.sel;
    assign en_q_o  = ctrl_q.en;

    // R1: reset clears both control registers
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (ctrl_q.sel == '0 && ctrl_q.en == '0));

    // R10: an enable-only write keeps the select value
    p_sel_kept_r10: assert property (@(posedge clk) disable iff (rst)
        (en_we && !sel_we) |=> $stable(ctrl_q.sel));

    // R10: a select-only write keeps the enables
    p_en_kept_r10: assert property (@(posedge clk) disable iff (rst)
        (sel_we && !en_we) |=> $stable(ctrl_q.en));

endmodule

// File: rtl/gpio_irq_route_mux.sv
module gpio_irq_route_mux #(
    parameter int unsigned B0_W     = gpio_irq_router_pkg::DEF_B0_W,
    parameter int unsigned B1_W     = gpio_irq_router_pkg::DEF_B1_W,
    parameter int unsigned SHARED_W = gpio_irq_router_pkg::DEF_SHARED_W,
    parameter int unsigned NB       = gpio_irq_router_pkg::NUM_BANKS,
    localparam int unsigned B1_SH_W = SHARED_W - B0_W,
    localparam int unsigned FIXED_W = B0_W + B1_W - SHARED_W
) (
    input  logic [SHARED_W-1:0] sel,
    input  logic [NB-1:0]       en,
    input  logic [B0_W-1:0]     b0,
    input  logic [B1_W-1:0]     b1,
    input  logic [SHARED_W-1:0] b2,
    output logic [SHARED_W-1:0] shared_o,
    output logic [FIXED_W-1:0]  fixed_o,
    output logic [NB-1:0]       nd_o
);
    import gpio_irq_router_pkg::*;

    // Default (unselected) source of each shared line
    logic [SHARED_W-1:0] home_src;

    for (genvar k = 0; k < SHARED_W; k++) begin : g_line
        if (k < B0_W) begin : g_b0
            assign home_src[k] = b0[k];
        end else begin : g_b1
            assign home_src[k] = b1[k-B0_W];
        end
        assign shared_o[k] = sel[k] ? b2[k] : home_src[k];
    end

    assign fixed_o = b1[B1_W-1:B1_SH_W];

    // Displaced sources fold into their bank's overflow line
    logic nd0_any, nd1_any, nd2_any;

    always_comb begin
        nd0_any = |(b0 & sel[B0_W-1:0]);
        nd1_any = |(b1[B1_SH_W-1:0] & sel[SHARED_W-1:B0_W]);
        nd2_any = |(b2 & ~sel);
        nd_o            = '0;
        nd_o[BANK_0]    = en[BANK_0] & nd0_any;
        nd_o[BANK_1]    = en[BANK_1] & nd1_any;
        nd_o[BANK_2]    = en[BANK_2] & nd2_any;
    end

endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router #(
    parameter int unsigned B0_W     = gpio_irq_router_pkg::DEF_B0_W,
    parameter int unsigned B1_W     = gpio_irq_router_pkg::DEF_B1_W,
    parameter int unsigned SHARED_W = gpio_irq_router_pkg::DEF_SHARED_W,
    localparam int unsigned NB      = gpio_irq_router_pkg::NUM_BANKS,
    localparam int unsigned FIXED_W = B0_W + B1_W - SHARED_W,
    localparam int unsigned OUT_W   = SHARED_W + FIXED_W + NB
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sel_we,
    input  logic [SHARED_W-1:0] sel_wdata,
    input  logic                nd_en_we,
    input  logic [NB-1:0]       nd_en_wdata,
    input  logic [B0_W-1:0]     bank0_irq,
    input  logic [B1_W-1:0]     bank1_irq,
    input  logic [SHARED_W-1:0] bank2_irq,
    output logic [OUT_W-1:0]    irq_out
);

    localparam int unsigned FIX_LO = SHARED_W;
    localparam int unsigned ND_LO  = SHARED_W + FIXED_W;
    localparam int unsigned B1_SH_W = SHARED_W - B0_W;

    logic [SHARED_W-1:0] sel_q;
    logic [NB-1:0]       en_q;
    logic [SHARED_W-1:0] shared_w;
    logic [FIXED_W-1:0]  fixed_w;
    logic [NB-1:0]       nd_w;

    gpio_irq_route_ctrl #(
        .SHARED_W (SHARED_W),
        .NB       (NB)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .sel_we    (sel_we),
        .sel_wdata (sel_wdata),
        .en_we     (nd_en_we),
        .en_wdata  (nd_en_wdata),
        .sel_q_o   (sel_q),
        .en_q_o    (en_q)
    );

    gpio_irq_route_mux #(
        .B0_W     (B0_W),
        .B1_W     (B1_W),
        .SHARED_W (SHARED_W),
        .NB       (NB)
    ) u_mux (
        .sel      (sel_q),
        .en       (en_q),
        .b0       (bank0_irq),
        .b1       (bank1_irq),
        .b2       (bank2_irq),
        .shared_o (shared_w),
        .fixed_o  (fixed_w),
        .nd_o     (nd_w)
    );

    typedef struct packed {
        logic [OUT_W-1:0] lines;
        logic             hist_ok;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d         = out_q;
        out_d.lines   = {nd_w, fixed_w, shared_w};
        out_d.hist_ok = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign irq_out = out_q.lines;

    // R1: outputs are quiet while reset is held
    p_quiet_in_reset_r1: assert property (@(posedge clk)
        rst |=> (irq_out == '0));

    // R5: fixed lines follow the top bank 1 bits one edge later
    p_fixed_follow_r5: assert property (@(posedge clk) disable iff (rst)
        out_q.hist_ok |-> irq_out[ND_LO-1:FIX_LO] == $past(bank1_irq[B1_W-1:B1_SH_W]));

    // R2: with nothing routed to bank 2, bank 0 owns its lines
    p_bank0_home_r2: assert property (@(posedge clk) disable iff (rst)
        (out_q.hist_ok && $past(sel_q) == '0) |-> irq_out[B0_W-1:0] == $past(bank0_irq));

    // R6: a disabled bank 0 overflow line stays low
    p_nd0_gated_r6: assert property (@(posedge clk) disable iff (rst)
        (out_q.hist_ok && !$past(en_q[0])) |-> !irq_out[ND_LO]);

    // R7: with no bank 1 line displaced, its overflow line stays low
    p_nd1_fixed_excluded_r7: assert property (@(posedge clk) disable iff (rst)
        (out_q.hist_ok && $past(sel_q[SHARED_W-1:B0_W]) == '0) |-> !irq_out[ND_LO+1]);

    // R8: with every line given to bank 2, its overflow line stays low
    p_nd2_none_r8: assert property (@(posedge clk) disable iff (rst)
        (out_q.hist_ok && $past(&sel_q)) |-> !irq_out[ND_LO+2]);

endmodule

// File: tb/gpio_irq_router_tb.sv
module gpio_irq_router_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        sel_we;
    logic [31:0] sel_wdata;
    logic        nd_en_we;
    logic [2:0]  nd_en_wdata;
    logic [13:0] bank0_irq;
    logic [23:0] bank1_irq;
    logic [31:0] bank2_irq;
    logic [40:0] irq_out;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    gpio_irq_router u_dut (
        .clk         (clk),
        .rst         (rst),
        .sel_we      (sel_we),
        .sel_wdata   (sel_wdata),
        .nd_en_we    (nd_en_we),
        .nd_en_wdata (nd_en_wdata),
        .bank0_irq   (bank0_irq),
        .bank1_irq   (bank1_irq),
        .bank2_irq   (bank2_irq),
        .irq_out     (irq_out)
    );

    // Vector fields: select, enables, bank0, bank1, bank2
    localparam int NV = 6;
    localparam logic [104:0] VEC [NV] = '{
        {32'h0000_0000, 3'b111, 14'h3FFF, 24'h00_0000, 32'hFFFF_FFFF},
        {32'hFFFF_FFFF, 3'b111, 14'h0001, 24'h00_0001, 32'h0000_0000},
        {32'h0000_FFFF, 3'b000, 14'h2AAA, 24'hFC_0000, 32'h5555_5555},
        {32'h0000_0000, 3'b010, 14'h0000, 24'hFC_0000, 32'h0000_0000},
        {32'hAAAA_AAAA, 3'b101, 14'h1555, 24'h03_FFFF, 32'h1234_5678},
        {32'h8000_2000, 3'b111, 14'h2000, 24'h02_0000, 32'h0000_0000}
    };

    // Expected outputs derived from the requirements
    function automatic logic [40:0] model(logic [31:0] s, logic [2:0] e,
                                          logic [13:0] a, logic [23:0] b,
                                          logic [31:0] c);
        logic [40:0] r;
        r = '0;
        for (int k = 0; k < 32; k++) begin
            if (s[k])        r[k] = c[k];
            else if (k < 14) r[k] = a[k];
            else             r[k] = b[k-14];
        end
        r[37:32] = b[23:18];
        r[38] = e[0] & |(a & s[13:0]);
        r[39] = e[1] & |(b[17:0] & s[31:14]);
        r[40] = e[2] & |(c & ~s);
        return r;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_ctrl(logic [31:0] s, logic [2:0] e);
        @(negedge clk);
        sel_we = 1'b1; sel_wdata = s;
        nd_en_we = 1'b1; nd_en_wdata = e;
        @(negedge clk);
        sel_we = 1'b0; nd_en_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [40:0] exp;
        rst = 1'b1;
        sel_we = 1'b0; sel_wdata = '0;
        nd_en_we = 1'b0; nd_en_wdata = '0;
        bank0_irq = '1; bank1_irq = '1; bank2_irq = '1;
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", 64'(irq_out), 64'h0);

        // R8: default select keeps bank 2 off direct lines; overflow disabled
        rst = 1'b0;
        bank0_irq = '0; bank1_irq = '0; bank2_irq = '1;
        @(negedge clk);
        chk("R8 bank2 hidden after reset", 64'(irq_out), 64'h0);
        write_ctrl(32'h0, 3'b100);
        @(negedge clk);
        chk("R8 bank2 overflow enabled", 64'(irq_out), 64'(41'(1) << 40));
        bank2_irq = '0;

        // Table walk
        for (int v = 0; v < NV; v++) begin
            logic [31:0] s; logic [2:0] e;
            logic [13:0] a; logic [23:0] b; logic [31:0] c;
            {s, e, a, b, c} = VEC[v];
            write_ctrl(s, e);
            bank0_irq = a; bank1_irq = b; bank2_irq = c;
            @(negedge clk);
            exp = model(s, e, a, b, c);
            chk("R2/R4 lines 0-13",  64'(irq_out[13:0]),  64'(exp[13:0]));
            chk("R3/R4 lines 14-31", 64'(irq_out[31:14]), 64'(exp[31:14]));
            chk("R5 fixed lines",    64'(irq_out[37:32]), 64'(exp[37:32]));
            chk("R6 bank0 overflow", 64'(irq_out[38]),    64'(exp[38]));
            chk("R7 bank1 overflow", 64'(irq_out[39]),    64'(exp[39]));
            chk("R8 bank2 overflow", 64'(irq_out[40]),    64'(exp[40]));
        end

        // R9: input latency of one edge
        write_ctrl(32'h0, 3'b000);
        bank0_irq = '0; bank1_irq = '0; bank2_irq = '0;
        @(negedge clk);
        bank0_irq = 14'h0020;
        #1;
        chk("R9 no change before edge", 64'(irq_out), 64'h0);
        @(negedge clk);
        chk("R9 input seen after one edge", 64'(irq_out), 64'h20);

        // R9: select write latency, line 5 moves to bank 2 (which is 0)
        @(negedge clk);
        sel_we = 1'b1; sel_wdata = 32'h0000_0020;
        @(negedge clk);
        sel_we = 1'b0;
        chk("R9 old routing one edge after write", 64'(irq_out), 64'h20);
        @(negedge clk);
        chk("R9 new routing two edges after write", 64'(irq_out), 64'h0);

        // R10: enable-only write leaves select; bank0 bit5 displaced -> line 38
        @(negedge clk);
        nd_en_we = 1'b1; nd_en_wdata = 3'b001;
        @(negedge clk);
        nd_en_we = 1'b0;
        @(negedge clk);
        chk("R10 select kept after enable write", 64'(irq_out), 64'(41'(1) << 38));

        // R10: select-only write leaves enables; bank1 bit0 displaced
        bank0_irq = '0; bank1_irq = 24'h00_0001;
        @(negedge clk);
        sel_we = 1'b1; sel_wdata = 32'h0000_4000;
        @(negedge clk);
        sel_we = 1'b0;
        nd_en_we = 1'b1; nd_en_wdata = 3'b010;
        @(negedge clk);
        nd_en_we = 1'b0;
        @(negedge clk);
        chk("R10 enables loaded, select kept", 64'(irq_out), 64'(41'(1) << 39));

        // R7: top bank1 bits never reach overflow even with all lines displaced
        write_ctrl(32'hFFFF_FFFF, 3'b111);
        bank1_irq = 24'hFC_0000;
        @(negedge clk);
        chk("R7 fixed bits excluded", 64'(irq_out[39]), 64'h0);
        chk("R5 fixed lines with full select", 64'(irq_out[37:32]), 64'h3F);

        // R1: reset mid-run clears outputs and registers
        rst = 1'b1;
        @(negedge clk);
        chk("R1 outputs cleared by reset", 64'(irq_out), 64'h0);
        rst = 1'b0;
        bank0_irq = 14'h0001; bank1_irq = '0; bank2_irq = 32'h1;
        @(negedge clk);
        chk("R1 select and enables cleared", 64'(irq_out), 64'h1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule